// File: doc/BRIEF.md
# Tapped Delay Path Unit

This block forms a single propagation path of a tapped-delay-line channel model. It takes a stream of signed 12-bit samples from one transmitting node, at most one per clock, marked by a valid flag. It delays the stream by a programmable whole number of samples, using a circular buffer held in on-chip RAM. It then scales the delayed sample by an unsigned 8-bit fine factor and by a coarse power of two applied as a left shift. The top 14 bits of the 30-bit result form the path output.

A host loads delay, fine scale, shift and a bypass flag into shadow registers through a small write port. A separate apply strobe moves the whole set into the active registers on one clock edge. Every sample carries the parameter set that was active when it entered the block, so no output sample is built from a mix of old and new settings. Summing several paths, the data converters and the host link belong to other blocks.

Top module: `tdl_path_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), out_valid and out_data are 0, and the active delay, scale, shift and bypass are all 0. A stream fed in before any configuration therefore yields out_data 0.
- R2: The latency is exactly 3 clocks. A sample presented with in_valid high at edge k appears at the output after edge k+2, and out_valid equals in_valid delayed by those same 3 register stages.
- R3: With delay d, a valid output carries the valid input sample that came d valid samples earlier. Delay 0 passes the current sample. Cycles with in_valid low neither store a sample nor advance the buffer position.
- R4: The output is bits [29:16] of the 30-bit two's-complement word ((x * scale) << shift), where x is the signed 12-bit sample and scale is unsigned 8-bit. Bits shifted above bit 29 are dropped, so an overflow wraps.
- R5: A shift value written above 14 is stored as 14.
- R6: A delay value written above 1535 (buffer depth 1536 minus one) is stored as 1535, and the largest delay works across the full buffer wrap.
- R7: A write (cfg_wr high) selects its field with cfg_sel: 0 is delay (all 16 data bits), 1 is scale (bits [7:0]), 2 is shift (all 16 bits), 3 is bypass (bit 0). A write goes only to the shadow set and has no effect on the output until an apply.
- R8: When cfg_apply is high at an edge, all shadow fields become active together at that edge. A sample presented at that same edge still uses the old set, and the next sample uses the new set. A write at the same edge as an apply is not part of that apply.
- R9: When bypass is active, the delay memory is skipped and the current sample is scaled, whatever the delay value. Samples are still stored, so clearing bypass restores the delayed stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_data | input | 12 | Signed input sample |
| cfg_wr | input | 1 | Shadow register write strobe |
| cfg_sel | input | 2 | Field select: 0 delay, 1 scale, 2 shift, 3 bypass |
| cfg_data | input | 16 | Write data |
| cfg_apply | input | 1 | Copy the shadow set into the active set |
| out_valid | output | 1 | Output sample present |
| out_data | output | 14 | Signed, truncated path output |

## Verification
The bench drives negative full-scale samples at the largest scale and shift to reach the wrapping truncation. A design that saturated, or that took the wrong slice of bits, would show a different value in those cycles. It moves an apply into the middle of a continuous stream. A design that let one pipeline stage pick up new settings before another would give exactly one mismatched sample at the boundary. It also covers gaps in the valid flag, clamped delay and shift writes, the largest delay across the buffer wrap, and switching bypass on and off. These show the faults that a free-running pointer, a missing clamp or a bypass that stops storing samples would cause.

// File: rtl/tdl_path_pkg.sv
package tdl_path_pkg;

   typedef enum logic [1:0] {
      SEL_DELAY  = 2'd0,
      SEL_SCALE  = 2'd1,
      SEL_SHIFT  = 2'd2,
      SEL_BYPASS = 2'd3
   } cfg_sel_e;

endpackage

// File: rtl/tdl_cfg_bank.sv
module tdl_cfg_bank
   import tdl_path_pkg::*;
#(
   parameter int CFG_W     = 16,
   parameter int DLY_W     = 11,
   parameter int SCALE_W   = 8,
   parameter int SHIFT_W   = 4,
   parameter int MAX_DELAY = 1535,
   parameter int MAX_SHIFT = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic [1:0]         cfg_sel,
   input  logic [CFG_W-1:0]   cfg_data,
   input  logic               cfg_apply,
   output logic [DLY_W-1:0]   act_delay,
   output logic [SCALE_W-1:0] act_scale,
   output logic [SHIFT_W-1:0] act_shift,
   output logic               act_bypass
);

   if (CFG_W < DLY_W || CFG_W < SCALE_W || CFG_W < SHIFT_W) begin : g_bad_cfg_w
      $error("tdl_cfg_bank: CFG_W too narrow for a field");
   end
   if (MAX_SHIFT >= (1 << SHIFT_W)) begin : g_bad_shift_w
      $error("tdl_cfg_bank: SHIFT_W cannot hold MAX_SHIFT");
   end
   if (MAX_DELAY >= (1 << DLY_W)) begin : g_bad_dly_w
      $error("tdl_cfg_bank: DLY_W cannot hold MAX_DELAY");
   end

   logic [DLY_W-1:0]   sh_delay;
   logic [SCALE_W-1:0] sh_scale;
   logic [SHIFT_W-1:0] sh_shift;
   logic               sh_bypass;

   logic [DLY_W-1:0]   delay_clamped;
   logic [SHIFT_W-1:0] shift_clamped;
   cfg_sel_e           sel;

   always_comb begin
      sel = cfg_sel_e'(cfg_sel);
      if (cfg_data > CFG_W'(MAX_DELAY)) delay_clamped = DLY_W'(MAX_DELAY);
      else                              delay_clamped = cfg_data[DLY_W-1:0];
      if (cfg_data > CFG_W'(MAX_SHIFT)) shift_clamped = SHIFT_W'(MAX_SHIFT);
      else                              shift_clamped = cfg_data[SHIFT_W-1:0];
   end

   // shadow set: host writes land here only
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_delay  <= '0;
         sh_scale  <= '0;
         sh_shift  <= '0;
         sh_bypass <= 1'b0;
      end else if (cfg_wr) begin
         case (sel)
            SEL_DELAY:  sh_delay  <= delay_clamped;
            SEL_SCALE:  sh_scale  <= cfg_data[SCALE_W-1:0];
            SEL_SHIFT:  sh_shift  <= shift_clamped;
            SEL_BYPASS: sh_bypass <= cfg_data[0];
            default:    ;
         endcase
      end
   end

   // active set: the whole set moves on one edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_delay  <= '0;
         act_scale  <= '0;
         act_shift  <= '0;
         act_bypass <= 1'b0;
      end else if (cfg_apply) begin
         act_delay  <= sh_delay;
         act_scale  <= sh_scale;
         act_shift  <= sh_shift;
         act_bypass <= sh_bypass;
      end
   end

   p_shift_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_shift <= SHIFT_W'(MAX_SHIFT)));

   p_delay_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_delay <= DLY_W'(MAX_DELAY)));

   p_hold_until_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_apply |=> ($stable(act_delay) && $stable(act_scale) &&
                      $stable(act_shift) && $stable(act_bypass)));

endmodule

// File: rtl/tdl_delay_buf.sv
module tdl_delay_buf #(
   parameter int DATA_W  = 12,
   parameter int DEPTH   = 1536,
   parameter int DLY_W   = 11,
   parameter bit HAS_MEM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [DLY_W-1:0]  delay,
   input  logic              bypass,
   output logic              tap_valid,
   output logic [DATA_W-1:0] tap_data
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("tdl_delay_buf: DEPTH must be at least 2");
   end
   if ((1 << DLY_W) < DEPTH) begin : g_bad_dly_w
      $error("tdl_delay_buf: DLY_W cannot address DEPTH");
   end

   if (HAS_MEM) begin : g_mem
      logic [DATA_W-1:0] mem [DEPTH];
      logic [DLY_W-1:0]  wp;
      logic [DLY_W-1:0]  raddr;
      logic              direct;

      always_comb begin
         direct = bypass || (delay == '0);
         if (wp >= delay) raddr = wp - delay;
         else             raddr = DLY_W'(32'(wp) + DEPTH - 32'(delay));
      end

      // storage keeps filling in every mode
      always_ff @(posedge clk) begin
         if (in_valid) mem[wp] <= in_data;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wp        <= '0;
            tap_valid <= 1'b0;
            tap_data  <= '0;
         end else begin
            tap_valid <= in_valid;
            if (in_valid) begin
               tap_data <= direct ? in_data : mem[raddr];
               if (wp == DLY_W'(DEPTH - 1)) wp <= '0;
               else                         wp <= wp + 1'b1;
            end
         end
      end

      p_rdaddr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (32'(raddr) < DEPTH));

      p_zero_delay_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && delay == '0) |=> (tap_data == $past(in_data)));

   end else begin : g_nomem
      logic unused_cfg;
      assign unused_cfg = ^{delay, bypass};

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tap_valid <= 1'b0;
            tap_data  <= '0;
         end else begin
            tap_valid <= in_valid;
            if (in_valid) tap_data <= in_data;
         end
      end
   end

endmodule

// File: rtl/tdl_gain_trunc.sv
module tdl_gain_trunc #(
   parameter int IN_W    = 12,
   parameter int SCALE_W = 8,
   parameter int SHIFT_W = 4,
   parameter int DP_W    = 30,
   parameter int OUT_W   = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tap_valid,
   input  logic [IN_W-1:0]    tap_data,
   input  logic [SCALE_W-1:0] scale,
   input  logic [SHIFT_W-1:0] shift,
   output logic               out_valid,
   output logic [OUT_W-1:0]   out_data
);

   localparam int PROD_W = IN_W + SCALE_W + 1;

   if (DP_W < PROD_W) begin : g_bad_dp
      $error("tdl_gain_trunc: DP_W narrower than the product");
   end
   if (OUT_W > DP_W) begin : g_bad_out
      $error("tdl_gain_trunc: OUT_W wider than DP_W");
   end

   logic signed [PROD_W-1:0] prod_next;
   logic signed [PROD_W-1:0] prod_q;
   logic [SHIFT_W-1:0]       shift_b;
   logic                     prod_vld;
   logic [DP_W-1:0]          wide;
   logic [DP_W-1:0]          shifted;

   // fine gain: signed sample times unsigned scale
   always_comb begin
      prod_next = $signed(tap_data) * $signed({1'b0, scale});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prod_vld <= 1'b0;
         prod_q   <= '0;
         shift_b  <= '0;
      end else begin
         prod_vld <= tap_valid;
         prod_q   <= prod_next;
         shift_b  <= shift;
      end
   end

   // coarse gain and truncation to the top OUT_W bits
   always_comb begin
      wide    = {{(DP_W - PROD_W){prod_q[PROD_W-1]}}, prod_q};
      shifted = wide << shift_b;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= prod_vld;
         out_data  <= shifted[DP_W-1 -: OUT_W];
      end
   end

   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (prod_vld == $past(tap_valid)));

   p_zero_scale_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_valid && scale == '0) |=> ##1 (out_data == '0));

endmodule

// File: rtl/tdl_path_unit.sv
module tdl_path_unit #(
   parameter int IN_W          = 12,
   parameter int OUT_W         = 14,
   parameter int SCALE_W       = 8,
   parameter int MAX_SHIFT     = 14,
   parameter int DP_W          = 30,
   parameter int DEPTH         = 1536,
   parameter int CFG_W         = 16,
   parameter bit HAS_DELAY_MEM = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   input  logic             cfg_wr,
   input  logic [1:0]       cfg_sel,
   input  logic [CFG_W-1:0] cfg_data,
   input  logic             cfg_apply,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data
);

   localparam int DLY_W     = $clog2(DEPTH);
   localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
   localparam int MAX_DELAY = DEPTH - 1;

   logic [DLY_W-1:0]   act_delay;
   logic [SCALE_W-1:0] act_scale;
   logic [SHIFT_W-1:0] act_shift;
   logic               act_bypass;

   logic               tap_valid;
   logic [IN_W-1:0]    tap_data;
   logic [SCALE_W-1:0] scale_a;
   logic [SHIFT_W-1:0] shift_a;

   tdl_cfg_bank #(
      .CFG_W     (CFG_W),
      .DLY_W     (DLY_W),
      .SCALE_W   (SCALE_W),
      .SHIFT_W   (SHIFT_W),
      .MAX_DELAY (MAX_DELAY),
      .MAX_SHIFT (MAX_SHIFT)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_sel    (cfg_sel),
      .cfg_data   (cfg_data),
      .cfg_apply  (cfg_apply),
      .act_delay  (act_delay),
      .act_scale  (act_scale),
      .act_shift  (act_shift),
      .act_bypass (act_bypass)
   );

   tdl_delay_buf #(
      .DATA_W  (IN_W),
      .DEPTH   (DEPTH),
      .DLY_W   (DLY_W),
      .HAS_MEM (HAS_DELAY_MEM)
   ) u_dly (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .delay     (act_delay),
      .bypass    (act_bypass),
      .tap_valid (tap_valid),
      .tap_data  (tap_data)
   );

   // gain settings are captured on the same edge as the delayed tap,
   // so each sample carries one consistent parameter set
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scale_a <= '0;
         shift_a <= '0;
      end else begin
         scale_a <= act_scale;
         shift_a <= act_shift;
      end
   end

   tdl_gain_trunc #(
      .IN_W    (IN_W),
      .SCALE_W (SCALE_W),
      .SHIFT_W (SHIFT_W),
      .DP_W    (DP_W),
      .OUT_W   (OUT_W)
   ) u_gain (
      .clk       (clk),
      .rst_n     (rst_n),
      .tap_valid (tap_valid),
      .tap_data  (tap_data),
      .scale     (scale_a),
      .shift     (shift_a),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

endmodule

// File: tb/tb_tdl_path_unit.sv
`timescale 1ns/1ps
module tb_tdl_path_unit;

   localparam int DEPTH = 1536;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [11:0] in_data = '0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [15:0] cfg_data = '0;
   logic        cfg_apply = 1'b0;
   logic        out_valid;
   logic [13:0] out_data;

   int n_tests = 0;
   int n_fail  = 0;
   string phase = "R1";
   bit done = 1'b0;

   always #10 clk = ~clk;

   tdl_path_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .cfg_apply(cfg_apply), .out_valid(out_valid), .out_data(out_data)
   );

   // ---------------- reference model ----------------
   int sh_dly, sh_scl, sh_shf, sh_byp;
   int m_dly, m_scl, m_shf, m_byp;
   int hist[$];
   bit p_v[3];
   bit p_k[3];
   int p_d[3];

   function automatic int gain_ref(int x, int s, int sh);
      longint p;
      logic [29:0] w;
      p = longint'(x) * longint'(s);
      w = 30'(p <<< sh);
      return int'($signed(w[29:16]));
   endfunction

   always @(posedge clk) begin
      bit ev, ek;
      int ed, eff;
      if (!rst_n) begin
         sh_dly = 0; sh_scl = 0; sh_shf = 0; sh_byp = 0;
         m_dly = 0; m_scl = 0; m_shf = 0; m_byp = 0;
         hist.delete();
         for (int i = 0; i < 3; i++) begin p_v[i] = 0; p_k[i] = 1; p_d[i] = 0; end
      end else begin
         ev = in_valid; ek = 1'b1; ed = 0;
         if (in_valid) begin
            hist.push_back(int'($signed(in_data)));
            if (hist.size() > DEPTH + 4) void'(hist.pop_front());
            eff = (m_byp != 0) ? 0 : m_dly;
            if (hist.size() > eff) ed = gain_ref(hist[hist.size() - 1 - eff], m_scl, m_shf);
            else ek = 1'b0;
         end
         p_v[2] = p_v[1]; p_k[2] = p_k[1]; p_d[2] = p_d[1];
         p_v[1] = p_v[0]; p_k[1] = p_k[0]; p_d[1] = p_d[0];
         p_v[0] = ev;     p_k[0] = ek;     p_d[0] = ed;
         if (cfg_apply) begin
            m_dly = sh_dly; m_scl = sh_scl; m_shf = sh_shf; m_byp = sh_byp;
         end
         if (cfg_wr) begin
            case (cfg_sel)
               2'd0: sh_dly = (int'(cfg_data) > DEPTH - 1) ? DEPTH - 1 : int'(cfg_data);
               2'd1: sh_scl = int'(cfg_data[7:0]);
               2'd2: sh_shf = (int'(cfg_data) > 14) ? 14 : int'(cfg_data);
               default: sh_byp = int'(cfg_data[0]);
            endcase
         end
      end
   end

   // ---------------- per-clock comparison ----------------
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_tests++;
         if (out_valid !== p_v[2]) begin
            n_fail++;
            $display("FAIL R2 out_valid actual=%0b expected=%0b t=%0t", out_valid, p_v[2], $time);
         end
         if (p_v[2] && p_k[2]) begin
            n_tests++;
            if (int'($signed(out_data)) != p_d[2]) begin
               n_fail++;
               $display("FAIL %s out_data actual=%0d expected=%0d t=%0t",
                        phase, $signed(out_data), p_d[2], $time);
            end
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 0; cfg_wr = 0; cfg_apply = 0;
      end
   endtask

   task automatic send(int x);
      @(negedge clk);
      in_valid = 1; in_data = 12'(x); cfg_wr = 0; cfg_apply = 0;
   endtask

   task automatic send_rand(int n, bit gaps);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = gaps ? ($urandom_range(0, 3) != 0) : 1'b1;
         in_data = 12'($urandom);
         cfg_wr = 0; cfg_apply = 0;
      end
   endtask

   task automatic wr(int sel, int data);
      @(negedge clk);
      in_valid = 0; cfg_wr = 1; cfg_sel = 2'(sel); cfg_data = 16'(data); cfg_apply = 0;
   endtask

   task automatic apply();
      @(negedge clk);
      in_valid = 0; cfg_wr = 0; cfg_apply = 1;
   endtask

   task automatic set_all(int d, int s, int sh, int b);
      wr(0, d); wr(1, s); wr(2, sh); wr(3, b); apply(); idle(1);
   endtask

   task automatic check_eq(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      check_eq("R1 out_valid after reset", int'(out_valid), 0);
      check_eq("R1 out_data after reset", int'(out_data), 0);

      // R1: unconfigured stream gives zero
      phase = "R1";
      send(2047); send(-2048); send(100); send_rand(8, 0);
      idle(4);

      // R4: gain and truncation patterns, zero delay
      phase = "R4";
      set_all(0, 255, 0, 0);
      send(2047); send(-2048); send(1); send(-1); send_rand(6, 0);
      set_all(0, 255, 14, 0);
      send(-2048); send(2047); send(3); send(-700);
      set_all(0, 1, 14, 0);
      send(-2048); send(2047); send(4); send(-5);
      set_all(0, 128, 7, 0);
      send_rand(20, 0);
      idle(4);

      // R2: explicit latency check, single sample through zero delay
      phase = "R2";
      set_all(0, 255, 8, 0);
      idle(3);
      send(1000);
      @(negedge clk); in_valid = 0;
      @(negedge clk);
      check_eq("R2 out_valid low before 3rd edge", int'(out_valid), 0);
      @(negedge clk);
      check_eq("R2 out_valid at 3rd edge", int'(out_valid), 1);
      check_eq("R2 out_data at 3rd edge", int'($signed(out_data)), gain_ref(1000, 255, 8));
      idle(3);

      // R7: shadow writes without apply have no effect
      phase = "R7";
      wr(1, 16'hFF03); wr(2, 2); wr(0, 9); wr(3, 1);
      send_rand(12, 0);
      idle(4);
      apply(); idle(1);
      send_rand(30, 0);

      // R8: apply in the middle of a continuous stream
      phase = "R8";
      wr(0, 3); wr(1, 77); wr(2, 5); wr(3, 0);
      send_rand(10, 0);
      @(negedge clk);
      in_valid = 1; in_data = 12'($urandom); cfg_apply = 1;
      cfg_wr = 1; cfg_sel = 2'd1; cfg_data = 16'd200;
      send_rand(15, 0);
      idle(4);

      // R3: delay with gaps in valid
      phase = "R3";
      set_all(5, 200, 6, 0);
      send_rand(60, 1);
      set_all(1, 90, 9, 0);
      send_rand(40, 1);
      idle(4);

      // R5: shift clamp
      phase = "R5";
      set_all(0, 1, 15, 0);
      send(-2048); send(2047); send(3);
      set_all(0, 1, 16'hFFFF, 0);
      send(-2048); send(1000);
      idle(4);

      // R6: delay clamp and full-depth wrap
      phase = "R6";
      set_all(4000, 150, 10, 0);
      send_rand(DEPTH + 300, 0);
      idle(4);

      // R9: bypass skips memory, then restores delayed stream
      phase = "R9";
      set_all(1535, 150, 10, 1);
      send_rand(40, 0);
      wr(3, 0); apply();
      send_rand(60, 0);
      idle(6);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule